// File: doc/BRIEF.md
# Codec Extended Audio Control Register

This block holds the extended audio status and control word of an audio codec and the logic that depends on it. A frame-based serial link controller sends it register writes and reads as a 7-bit index, a 16-bit data word and a write strobe. Read data is combinational from the addressed index. Writes take effect on the rising clock edge that samples the strobe.

The control word carries four fields. The variable-rate enable decides whether the four converter rate registers report their stored values or a fixed 48 kHz. The double-rate audio enable cancels the DAC slot-pair choice. The SPDIF enable drives the output-enable of the SPDIF pin and locks most of the SPDIF control register while the transmitter runs. The SPDIF slot-pair field picks which link slots feed the SPDIF transmitter. An external double-rate SPDIF request moves the primary pair to slots 3/4 and uses the chosen pair as the secondary stream.

The block also holds the SPDIF control register and the four rate registers, so that the interlocks act on real storage. The frame engine, the DACs and the SPDIF encoder are outside it.

Top module: `codec_xaudio_regs`

## Requirements
- R1: After reset the control word at index 2Ah reads 0030h, index 3Ah reads 0000h, the rate registers 2Ch, 2Eh, 30h and 32h read BB80h, and `spdif_oe` is 0.
- R2: A write to 2Ah stores data bits 5:4 (SPDIF slot pair), bit 2 (SPDIF enable), bit 1 (double-rate audio) and bit 0 (variable rate). Bit 3 and bits 15:6 always read 0, whatever was written.
- R3: `spdif_oe` equals the stored SPDIF enable (2Ah bit 2). When it is 0 the SPDIF pin is high impedance.
- R4: The slot-pair field maps 00 to slots 3/4, 01 to 7/8, 10 to 6/9 and 11 to 10/11 (left/right). With `spdif_dbl_req` low, both the primary and the secondary slot outputs carry that pair, and `spdif_sec_act` is 0.
- R5: With `spdif_dbl_req` high, the primary slots are 3/4, the secondary slots follow the field and `spdif_sec_act` is 1. Field 00 then gives 3/4 for both pairs, and this is a legal mode.
- R6: While the SPDIF enable is 0, a write to 3Ah updates all 16 bits. While it is 1, bits 15 and 13:0 keep their value and only bit 14 takes the written data.
- R7: While double-rate audio (2Ah bit 1) is 1, `dac_slot_eff` is 00 whatever `dac_slot_req` is. Otherwise it equals `dac_slot_req`. `dac_dbl_rate` mirrors the bit.
- R8: While variable rate (2Ah bit 0) is 0, the four rate registers read BB80h and every lane of `rate_eff` is BB80h. Writes to them are still stored.
- R9: While variable rate is 1, each rate register reads its last written value, including values written while variable rate was 0, and its `rate_eff` lane carries the same value.
- R10: A read of any index other than 2Ah, 3Ah, 2Ch, 2Eh, 30h or 32h returns 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_idx | input | 7 | Register index of the access |
| reg_wdata | input | 16 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 16 | Read data for `reg_idx`, combinational |
| spdif_dbl_req | input | 1 | Double-rate SPDIF request from the SPDIF control path |
| dac_slot_req | input | 2 | DAC slot-pair selection from the DAC control register |
| spdif_oe | output | 1 | Output enable of the SPDIF pin |
| spdif_pri_l | output | 4 | Primary left SPDIF source slot |
| spdif_pri_r | output | 4 | Primary right SPDIF source slot |
| spdif_sec_l | output | 4 | Secondary left SPDIF source slot |
| spdif_sec_r | output | 4 | Secondary right SPDIF source slot |
| spdif_sec_act | output | 1 | Secondary pair in use (double-rate SPDIF) |
| spdif_ctrl | output | 16 | Contents of the SPDIF control register |
| dac_dbl_rate | output | 1 | Double-rate audio enable to the DACs |
| dac_slot_eff | output | 2 | DAC slot-pair selection after the double-rate override |
| rate_eff | output | 64 | Effective rates of the four converters, lane 0 at bits 15:0 (2Ch) |

## Verification
Every stored result is due one edge after its write. The strobe is raised on a falling edge and dropped on the next falling edge, and the register outputs and readback are checked half a cycle after the edge that wrote them. The slot mapping, the DAC override and the read mux are combinational from stored state and the present inputs. The bench changes the input at a falling edge and samples one nanosecond later, before the next rising edge. The lock on the SPDIF control register is checked by reading 3Ah back right after a refused write, before any other write.

// File: rtl/codec_xa_pkg.sv
// Package: shared indices, widths and slot decode for the extended audio
// control block. Assumes 7-bit register indices and 16-bit data.
package codec_xa_pkg;

    localparam int IDX_W    = 7;
    localparam int DW       = 16;
    localparam int SLOT_W   = 4;

    localparam logic [IDX_W-1:0] IDX_XCTRL   = 7'h2A;
    localparam logic [IDX_W-1:0] IDX_SPDIF   = 7'h3A;
    localparam logic [IDX_W-1:0] IDX_RATE0   = 7'h2C;

    localparam logic [DW-1:0] RATE_48K = 16'hBB80;
    localparam logic [DW-1:0] XCTRL_RST = 16'h0030;

    // Bit positions inside the control word
    localparam int B_VAR   = 0;
    localparam int B_DRA   = 1;
    localparam int B_SPEN  = 2;
    localparam int B_PAIR  = 4;

    typedef struct packed {
        logic [SLOT_W-1:0] left;
        logic [SLOT_W-1:0] right;
    } slot_pair_t;

    // Map a 2-bit pair code to its left/right slot numbers.
    function automatic slot_pair_t pair_decode(input logic [1:0] code);
        slot_pair_t p;
        case (code)
            2'b00:   begin p.left = 4'd3;  p.right = 4'd4;  end
            2'b01:   begin p.left = 4'd7;  p.right = 4'd8;  end
            2'b10:   begin p.left = 4'd6;  p.right = 4'd9;  end
            default: begin p.left = 4'd10; p.right = 4'd11; end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/xa_ctrl_reg.sv
// Module: xa_ctrl_reg
// Holds the extended control word (slot pair, SPDIF enable, double-rate,
// variable rate) and the SPDIF control register with its write lock.
// Assumes a single-cycle write strobe; the lock uses the enable value
// present before the write edge.
module xa_ctrl_reg
    import codec_xa_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int W  = DW,
    parameter int LOCK_FREE_BIT = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  wdata,
    input  logic          we,
    output logic [1:0]    pair_code,
    output logic          spdif_en,
    output logic          dra_en,
    output logic          var_en,
    output logic [W-1:0]  spdif_word
);
    localparam logic [W-1:0] FREE_MASK = W'(1) << LOCK_FREE_BIT;

    logic wr_ctrl, wr_spdif;
    logic [W-1:0] spdif_mask;

    assign wr_ctrl  = we && (idx == IDX_XCTRL);
    assign wr_spdif = we && (idx == IDX_SPDIF);

    // Bits of the SPDIF word a write may change this cycle.
    always_comb spdif_mask = spdif_en ? FREE_MASK : '1;

    // Control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_code <= XCTRL_RST[B_PAIR +: 2];
            spdif_en  <= 1'b0;
            dra_en    <= 1'b0;
            var_en    <= 1'b0;
        end else if (wr_ctrl) begin
            pair_code <= wdata[B_PAIR +: 2];
            spdif_en  <= wdata[B_SPEN];
            dra_en    <= wdata[B_DRA];
            var_en    <= wdata[B_VAR];
        end
    end

    // SPDIF control word storage with the enable lock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            spdif_word <= '0;
        else if (wr_spdif)
            spdif_word <= (wdata & spdif_mask) | (spdif_word & ~spdif_mask);
    end
endmodule

// File: rtl/xa_rate_bank.sv
// Module: xa_rate_bank
// A bank of converter rate registers at consecutive even indices. Each
// keeps the last written value; while variable rate is off, every lane
// reports the fixed default rate instead. Assumes even index spacing.
module xa_rate_bank
    import codec_xa_pkg::*;
#(
    parameter int IW      = IDX_W,
    parameter int W       = DW,
    parameter int N_RATES = 4,
    parameter logic [IW-1:0] BASE_IDX = IDX_RATE0,
    parameter logic [W-1:0]  FIXED    = RATE_48K
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    idx,
    input  logic [W-1:0]     wdata,
    input  logic             we,
    input  logic             var_en,
    output logic [N_RATES*W-1:0] lanes,
    output logic             hit,
    output logic [W-1:0]     rdata
);
    localparam int STEP = 2;

    logic [N_RATES-1:0] sel;
    logic [W-1:0] stored [N_RATES];

    for (genvar g = 0; g < N_RATES; g++) begin : g_rate
        localparam logic [IW-1:0] MY_IDX = BASE_IDX + IW'(g * STEP);

        assign sel[g] = (idx == MY_IDX);

        // Rate register g: takes any write addressed to it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stored[g] <= FIXED;
            else if (we && sel[g])
                stored[g] <= wdata;
        end

        assign lanes[g*W +: W] = var_en ? stored[g] : FIXED;
    end

    assign hit = |sel;

    // Readback of the selected lane.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_RATES; i++)
            if (sel[i]) rdata = lanes[i*W +: W];
    end
endmodule

// File: rtl/xa_slot_map.sv
// Module: xa_slot_map
// Turns the slot-pair code and the double-rate SPDIF request into source
// slot numbers, and applies the double-rate audio override to the DAC
// slot selection. Purely combinational.
module xa_slot_map
    import codec_xa_pkg::*;
#(
    parameter int SW = SLOT_W
) (
    input  logic [1:0]    pair_code,
    input  logic          dbl_req,
    input  logic          dra_en,
    input  logic [1:0]    dac_req,
    output logic [SW-1:0] pri_l,
    output logic [SW-1:0] pri_r,
    output logic [SW-1:0] sec_l,
    output logic [SW-1:0] sec_r,
    output logic          sec_act,
    output logic [1:0]    dac_eff
);
    slot_pair_t chosen, base;

    // Decode the chosen pair and the fixed 3/4 pair.
    always_comb begin
        chosen = pair_decode(pair_code);
        base   = pair_decode(2'b00);
    end

    // Primary comes from 3/4 in double-rate mode, else the chosen pair.
    always_comb begin
        pri_l   = dbl_req ? base.left  : chosen.left;
        pri_r   = dbl_req ? base.right : chosen.right;
        sec_l   = chosen.left;
        sec_r   = chosen.right;
        sec_act = dbl_req;
    end

    // Double-rate audio cancels the DAC slot selection.
    always_comb dac_eff = dra_en ? 2'b00 : dac_req;
endmodule

// File: rtl/codec_xaudio_regs.sv
// Module: codec_xaudio_regs (top)
// Extended audio control register with its interlocks: SPDIF write lock,
// fixed-rate readback, DAC slot override and SPDIF slot mapping.
// Assumes accesses from a link controller with combinational read data.
module codec_xaudio_regs
    import codec_xa_pkg::*;
#(
    parameter int N_RATES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      reg_idx,
    input  logic [DW-1:0]         reg_wdata,
    input  logic                  reg_we,
    output logic [DW-1:0]         reg_rdata,
    input  logic                  spdif_dbl_req,
    input  logic [1:0]            dac_slot_req,
    output logic                  spdif_oe,
    output logic [SLOT_W-1:0]     spdif_pri_l,
    output logic [SLOT_W-1:0]     spdif_pri_r,
    output logic [SLOT_W-1:0]     spdif_sec_l,
    output logic [SLOT_W-1:0]     spdif_sec_r,
    output logic                  spdif_sec_act,
    output logic [DW-1:0]         spdif_ctrl,
    output logic                  dac_dbl_rate,
    output logic [1:0]            dac_slot_eff,
    output logic [N_RATES*DW-1:0] rate_eff
);
    logic [1:0]    pair_code;
    logic          spdif_en, dra_en, var_en;
    logic          rate_hit;
    logic [DW-1:0] rate_rdata;
    logic [DW-1:0] ctrl_word;

    xa_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (reg_idx),
        .wdata      (reg_wdata),
        .we         (reg_we),
        .pair_code  (pair_code),
        .spdif_en   (spdif_en),
        .dra_en     (dra_en),
        .var_en     (var_en),
        .spdif_word (spdif_ctrl)
    );

    xa_rate_bank #(.N_RATES(N_RATES)) u_rates (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx    (reg_idx),
        .wdata  (reg_wdata),
        .we     (reg_we),
        .var_en (var_en),
        .lanes  (rate_eff),
        .hit    (rate_hit),
        .rdata  (rate_rdata)
    );

    xa_slot_map u_slots (
        .pair_code (pair_code),
        .dbl_req   (spdif_dbl_req),
        .dra_en    (dra_en),
        .dac_req   (dac_slot_req),
        .pri_l     (spdif_pri_l),
        .pri_r     (spdif_pri_r),
        .sec_l     (spdif_sec_l),
        .sec_r     (spdif_sec_r),
        .sec_act   (spdif_sec_act),
        .dac_eff   (dac_slot_eff)
    );

    // Assemble the control word; reserved and unused bits stay 0.
    always_comb begin
        ctrl_word = '0;
        ctrl_word[B_PAIR +: 2] = pair_code;
        ctrl_word[B_SPEN]      = spdif_en;
        ctrl_word[B_DRA]       = dra_en;
        ctrl_word[B_VAR]       = var_en;
    end

    // Read mux over the implemented indices.
    always_comb begin
        if (reg_idx == IDX_XCTRL)      reg_rdata = ctrl_word;
        else if (reg_idx == IDX_SPDIF) reg_rdata = spdif_ctrl;
        else if (rate_hit)             reg_rdata = rate_rdata;
        else                           reg_rdata = '0;
    end

    assign spdif_oe     = spdif_en;
    assign dac_dbl_rate = dra_en;
endmodule

// File: rtl/codec_xaudio_regs_chk.sv
// Module: codec_xaudio_regs_chk
// Property checker for codec_xaudio_regs, attached with bind below.
module codec_xaudio_regs_chk
    import codec_xa_pkg::*;
#(
    parameter int N_RATES = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [IDX_W-1:0]      reg_idx,
    input logic [DW-1:0]         reg_wdata,
    input logic                  reg_we,
    input logic [DW-1:0]         reg_rdata,
    input logic                  spdif_dbl_req,
    input logic                  spdif_oe,
    input logic [SLOT_W-1:0]     spdif_pri_l,
    input logic [SLOT_W-1:0]     spdif_pri_r,
    input logic [DW-1:0]         spdif_ctrl,
    input logic                  dac_dbl_rate,
    input logic [1:0]            dac_slot_eff,
    input logic                  var_en,
    input logic [N_RATES*DW-1:0] rate_eff
);
    logic known_idx;
    assign known_idx = (reg_idx == 7'h2A) || (reg_idx == 7'h3A) ||
                       (reg_idx == 7'h2C) || (reg_idx == 7'h2E) ||
                       (reg_idx == 7'h30) || (reg_idx == 7'h32);

    // R3: the pin enable follows the last enable written to 2Ah.
    p_oe_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_idx == 7'h2A) |=> (spdif_oe == $past(reg_wdata[2])));

    // R6: a write while enabled leaves bits 15 and 13:0 unchanged.
    p_spdif_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_idx == 7'h3A && spdif_oe) |=>
        (spdif_ctrl[15] == $past(spdif_ctrl[15]) &&
         spdif_ctrl[13:0] == $past(spdif_ctrl[13:0])));

    // R7: double-rate audio forces the DAC slot selection to 00.
    p_dac_override_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dac_dbl_rate |-> (dac_slot_eff == 2'b00));

    // R5: double-rate SPDIF takes the primary pair from slots 3/4.
    p_dbl_primary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spdif_dbl_req |-> (spdif_pri_l == 4'd3 && spdif_pri_r == 4'd4));

    // R8: fixed rate on every lane while variable rate is off.
    p_fixed_rate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !var_en |-> (rate_eff == {N_RATES{RATE_48K}}));

    // R10: unimplemented indices read zero.
    p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !known_idx |-> (reg_rdata == '0));

    // R2: reserved and unused control bits read zero.
    p_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == 7'h2A) |-> (reg_rdata[15:6] == '0 && reg_rdata[3] == 1'b0));
endmodule

bind codec_xaudio_regs codec_xaudio_regs_chk #(.N_RATES(N_RATES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_idx       (reg_idx),
    .reg_wdata     (reg_wdata),
    .reg_we        (reg_we),
    .reg_rdata     (reg_rdata),
    .spdif_dbl_req (spdif_dbl_req),
    .spdif_oe      (spdif_oe),
    .spdif_pri_l   (spdif_pri_l),
    .spdif_pri_r   (spdif_pri_r),
    .spdif_ctrl    (spdif_ctrl),
    .dac_dbl_rate  (dac_dbl_rate),
    .dac_slot_eff  (dac_slot_eff),
    .var_en        (var_en),
    .rate_eff      (rate_eff)
);

// File: tb/codec_xaudio_regs_test.sv
// Directed bench for codec_xaudio_regs: one task per scenario.
module codec_xaudio_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  reg_idx = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_rdata;
    logic        spdif_dbl_req = 1'b0;
    logic [1:0]  dac_slot_req = 2'b00;
    logic        spdif_oe;
    logic [3:0]  spdif_pri_l, spdif_pri_r, spdif_sec_l, spdif_sec_r;
    logic        spdif_sec_act;
    logic [15:0] spdif_ctrl;
    logic        dac_dbl_rate;
    logic [1:0]  dac_slot_eff;
    logic [63:0] rate_eff;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    codec_xaudio_regs uut (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .spdif_dbl_req(spdif_dbl_req),
        .dac_slot_req(dac_slot_req), .spdif_oe(spdif_oe),
        .spdif_pri_l(spdif_pri_l), .spdif_pri_r(spdif_pri_r),
        .spdif_sec_l(spdif_sec_l), .spdif_sec_r(spdif_sec_r),
        .spdif_sec_act(spdif_sec_act), .spdif_ctrl(spdif_ctrl),
        .dac_dbl_rate(dac_dbl_rate), .dac_slot_eff(dac_slot_eff),
        .rate_eff(rate_eff)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Write on one edge; returns half a cycle after the writing edge.
    task automatic wr(input logic [6:0] i, input logic [15:0] d);
        @(negedge clk);
        reg_idx = i; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [6:0] i, input logic [15:0] exp);
        reg_idx = i;
        #1;
        check(req, {48'h0, reg_rdata}, {48'h0, exp});
    endtask

    task automatic t_reset;
        rd_check("R1", 7'h2A, 16'h0030);
        rd_check("R1", 7'h3A, 16'h0000);
        for (int k = 0; k < 4; k++) rd_check("R1", 7'h2C + 7'(2*k), 16'hBB80);
        check("R1", {63'h0, spdif_oe}, 64'h0);
    endtask

    task automatic t_ctrl_fields;
        wr(7'h2A, 16'hFFFF);
        rd_check("R2", 7'h2A, 16'h0037);
        check("R3", {63'h0, spdif_oe}, 64'h1);
        wr(7'h2A, 16'h0008);
        rd_check("R2", 7'h2A, 16'h0000);
        check("R3", {63'h0, spdif_oe}, 64'h0);
    endtask

    task automatic t_slot_map;
        logic [7:0] exp_pair [4];
        exp_pair[0] = 8'h34; exp_pair[1] = 8'h78; exp_pair[2] = 8'h69; exp_pair[3] = 8'hAB;
        for (int c = 0; c < 4; c++) begin
            wr(7'h2A, 16'(c << 4));
            spdif_dbl_req = 1'b0;
            #1;
            check("R4", {48'h0, spdif_pri_l, spdif_pri_r, spdif_sec_l, spdif_sec_r},
                  {48'h0, exp_pair[c], exp_pair[c]});
            check("R4", {63'h0, spdif_sec_act}, 64'h0);
            spdif_dbl_req = 1'b1;
            #1;
            check("R5", {48'h0, spdif_pri_l, spdif_pri_r, spdif_sec_l, spdif_sec_r},
                  {48'h0, 8'h34, exp_pair[c]});
            check("R5", {63'h0, spdif_sec_act}, 64'h1);
        end
        spdif_dbl_req = 1'b0;
    endtask

    task automatic t_spdif_lock;
        wr(7'h2A, 16'h0000);
        wr(7'h3A, 16'hA5A5);
        rd_check("R6", 7'h3A, 16'hA5A5);
        wr(7'h2A, 16'h0004);
        wr(7'h3A, 16'h5A5A);
        rd_check("R6", 7'h3A, 16'hE5A5);
        wr(7'h3A, 16'h0000);
        rd_check("R6", 7'h3A, 16'hA5A5);
        wr(7'h2A, 16'h0000);
        wr(7'h3A, 16'h1234);
        rd_check("R6", 7'h3A, 16'h1234);
    endtask

    task automatic t_dac_override;
        wr(7'h2A, 16'h0002);
        for (int s = 0; s < 4; s++) begin
            dac_slot_req = 2'(s);
            #1;
            check("R7", {62'h0, dac_slot_eff}, 64'h0);
        end
        check("R7", {63'h0, dac_dbl_rate}, 64'h1);
        wr(7'h2A, 16'h0000);
        dac_slot_req = 2'b10;
        #1;
        check("R7", {62'h0, dac_slot_eff}, 64'h2);
        check("R7", {63'h0, dac_dbl_rate}, 64'h0);
    endtask

    task automatic t_rates;
        wr(7'h2A, 16'h0000);
        for (int k = 0; k < 4; k++) wr(7'h2C + 7'(2*k), 16'h1F40 + 16'(k));
        for (int k = 0; k < 4; k++) rd_check("R8", 7'h2C + 7'(2*k), 16'hBB80);
        check("R8", rate_eff, {4{16'hBB80}});
        wr(7'h2A, 16'h0001);
        for (int k = 0; k < 4; k++) rd_check("R9", 7'h2C + 7'(2*k), 16'h1F40 + 16'(k));
        check("R9", rate_eff, {16'h1F43, 16'h1F42, 16'h1F41, 16'h1F40});
        wr(7'h30, 16'hAC44);
        rd_check("R9", 7'h30, 16'hAC44);
        wr(7'h2A, 16'h0000);
        rd_check("R8", 7'h30, 16'hBB80);
    endtask

    task automatic t_unmapped;
        wr(7'h28, 16'hFFFF);
        rd_check("R10", 7'h28, 16'h0000);
        rd_check("R10", 7'h2B, 16'h0000);
        rd_check("R10", 7'h34, 16'h0000);
        rd_check("R10", 7'h7F, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_fields();
        t_slot_map();
        t_spdif_lock();
        t_dac_override();
        t_rates();
        t_unmapped();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule